// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Refresh Counter and Test-Mode Flag

This block is the control front end on the device side of an asynchronous-strobe dynamic memory. A fast internal clock samples the active-low row strobe, column strobe and write enable. The relative order of their edges decides what kind of memory cycle is in progress. The block supplies the row address to the array. That row comes either from the address pins or from an internal refresh row counter. The block also latches the column address when the column strobe falls.

Five cycle types are recognised:
- ordinary access with a row taken from the pins;
- row-strobe-only refresh;
- column-before-row refresh;
- column-before-row refresh with write enable low, which also switches the device into test mode;
- counter test, where the column strobe is cycled again inside a column-before-row cycle.

A plain column-before-row refresh or a row-only refresh puts the device back into normal mode. The refresh counter advances once at the end of every cycle that used it.

Top module: `dram_rfsh_ctl`

## Requirements
- R1: After synchronous reset the outputs are as follows: `cycle_kind` = 0, `test_mode` = 0, `rfsh_row` = 0, `row_addr` = 0, `col_addr` = 0, `col_load` = 0 and `rfsh_done` = 0.
- R2: When `ras_n` falls while `cas_n` is high, `cycle_kind` becomes 1 and `row_addr` takes the value on `addr_in`. All outputs follow a strobe change two clock edges after the change is sampled.
- R3: A fall of `cas_n` during a cycle of kind 1 or 2 gives the following. `cycle_kind` becomes 2, `col_addr` takes `addr_in`, and `col_load` pulses high for one clock. Each further fall of `cas_n` in the same cycle (page mode) loads a new column.
- R4: When `ras_n` rises while the cycle is still kind 1 (no column strobe seen), `rfsh_done` pulses for one clock and `test_mode` is cleared.
- R5: When `cas_n` is already low as `ras_n` falls and `we_n` is high, `cycle_kind` becomes 3. In this case `row_addr` takes the refresh counter value and ignores `addr_in`, and `test_mode` is cleared.
- R6: At the rise of `ras_n` that ends a cycle of kind 3, 4 or 5, `rfsh_done` pulses and `rfsh_row` increments by one. The counter wraps from 1023 to 0.
- R7: When both `cas_n` and `we_n` are low as `ras_n` falls, `cycle_kind` becomes 4 and `test_mode` is set. The cycle is still a counter refresh: the row comes from the counter and the counter advances at its end.
- R8: In a cycle of kind 3 or 4, a later fall of `cas_n` (after `cas_n` has gone high) gives the following. `cycle_kind` becomes 5, `col_addr` takes `addr_in`, and `col_load` pulses. `row_addr` keeps the counter value.
- R9: On the rise of `ras_n`, `cycle_kind` returns to 0. An access cycle (kind 2) ends without a `rfsh_done` pulse and leaves `test_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr_in | input | 10 | Multiplexed address pins |
| row_addr | output | 10 | Row driven to the array for the current cycle |
| col_addr | output | 10 | Last latched column |
| col_load | output | 1 | One-clock pulse when a column is latched |
| cycle_kind | output | 3 | 0 idle, 1 row open, 2 access, 3 counter refresh, 4 test entry, 5 counter test |
| rfsh_done | output | 1 | One-clock pulse at the end of a refresh cycle |
| test_mode | output | 1 | Test-mode flag |
| rfsh_row | output | 10 | Internal refresh row counter |

## Verification
The case that is hardest to reach from the ports is the wrap of the refresh counter from 1023 to 0. It needs more than a thousand complete column-before-row cycles, so the bench runs a tight directed loop of plain refresh cycles and then checks the counter and the row handed out in the next cycle. The counter-test cycle is also hard to reach, because the column strobe has to be raised and dropped again while the row strobe is held low. Random cycles mix it with test-mode entry and exit in arbitrary order, and a reference model tracks the flag and the counter.

// File: rtl/dram_ctl_pkg.sv
// Package: shared cycle-kind encoding for the strobe decoder.
package dram_ctl_pkg;
    typedef enum logic [2:0] {
        K_IDLE       = 3'd0,
        K_ROW        = 3'd1,
        K_ACCESS     = 3'd2,
        K_CBR        = 3'd3,
        K_TEST_ENTRY = 3'd4,
        K_CNT_TEST   = 3'd5
    } cyc_kind_e;
endpackage

// File: rtl/dram_strobe_sampler.sv
// Samples the asynchronous strobes and address on the internal clock
// and produces single-cycle edge flags.
// Assumes that the strobes are held for at least two clocks between edges.
module dram_strobe_sampler #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              ras_fall,
    output logic              ras_rise,
    output logic              cas_fall,
    output logic              cas_lvl,
    output logic              we_lvl,
    output logic [ADDR_W-1:0] addr_s
);
    logic s_ras, p_ras, s_cas, p_cas, s_we;

    // Sample stage plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ras  <= 1'b1;
            p_ras  <= 1'b1;
            s_cas  <= 1'b1;
            p_cas  <= 1'b1;
            s_we   <= 1'b1;
            addr_s <= '0;
        end else begin
            s_ras  <= ras_n;
            p_ras  <= s_ras;
            s_cas  <= cas_n;
            p_cas  <= s_cas;
            s_we   <= we_n;
            addr_s <= addr_in;
        end
    end

    // Edge flags from the sampled and delayed levels.
    always_comb begin
        ras_fall = p_ras & ~s_ras;
        ras_rise = ~p_ras & s_ras;
        cas_fall = p_cas & ~s_cas;
        cas_lvl  = s_cas;
        we_lvl   = s_we;
    end
endmodule

// File: rtl/dram_rfsh_counter.sv
// Internal refresh row counter. It wraps naturally at 2**W and
// advances by one on each inc pulse.
module dram_rfsh_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    // Count refresh cycles that consumed the counter row.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + ONE;
    end
endmodule

// File: rtl/dram_cycle_classifier.sv
// Classifies each row-strobe cycle from the order of the strobe edges.
// It chooses the row source, latches columns and keeps the test-mode flag.
// Assumes that the edge flags come from dram_strobe_sampler.
module dram_cycle_classifier
    import dram_ctl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_lvl,
    input  logic              we_lvl,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [ADDR_W-1:0] ctr,
    output cyc_kind_e         state,
    output logic [ADDR_W-1:0] row,
    output logic [ADDR_W-1:0] col,
    output logic              col_load,
    output logic              rfsh_done,
    output logic              tm,
    output logic              ctr_inc
);
    logic uses_ctr;

    // Cycle kinds that take their row from the refresh counter.
    always_comb begin
        uses_ctr = (state == K_CBR) || (state == K_TEST_ENTRY) || (state == K_CNT_TEST);
        ctr_inc  = ras_rise && uses_ctr;
    end

    // Cycle state, address latches and mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= K_IDLE;
            row       <= '0;
            col       <= '0;
            col_load  <= 1'b0;
            rfsh_done <= 1'b0;
            tm        <= 1'b0;
        end else begin
            col_load  <= 1'b0;
            rfsh_done <= 1'b0;
            if (ras_rise && state != K_IDLE) begin
                state     <= K_IDLE;
                rfsh_done <= (state != K_ACCESS);
                if (state == K_ROW) tm <= 1'b0;
            end else begin
                case (state)
                    K_IDLE: begin
                        if (ras_fall) begin
                            if (!cas_lvl) begin
                                row <= ctr;
                                if (!we_lvl) begin
                                    state <= K_TEST_ENTRY;
                                    tm    <= 1'b1;
                                end else begin
                                    state <= K_CBR;
                                    tm    <= 1'b0;
                                end
                            end else begin
                                row   <= addr_s;
                                state <= K_ROW;
                            end
                        end
                    end
                    K_ROW, K_ACCESS: begin
                        if (cas_fall) begin
                            col      <= addr_s;
                            col_load <= 1'b1;
                            state    <= K_ACCESS;
                        end
                    end
                    K_CBR, K_TEST_ENTRY, K_CNT_TEST: begin
                        if (cas_fall) begin
                            col      <= addr_s;
                            col_load <= 1'b1;
                            state    <= K_CNT_TEST;
                        end
                    end
                    default: state <= K_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dram_rfsh_ctl.sv
// Top level: strobe sampler, cycle classifier and refresh counter.
// All outputs are registered and follow a sampled strobe edge by two clocks.
module dram_rfsh_ctl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              col_load,
    output logic [2:0]        cycle_kind,
    output logic              rfsh_done,
    output logic              test_mode,
    output logic [ADDR_W-1:0] rfsh_row
);
    import dram_ctl_pkg::*;

    logic              ras_fall, ras_rise, cas_fall, cas_lvl, we_lvl, ctr_inc;
    logic [ADDR_W-1:0] addr_s;
    cyc_kind_e         kind;

    dram_strobe_sampler #(.ADDR_W(ADDR_W)) smp_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr_in(addr_in), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_lvl(cas_lvl), .we_lvl(we_lvl), .addr_s(addr_s)
    );

    dram_cycle_classifier #(.ADDR_W(ADDR_W)) cls_i (
        .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_lvl(cas_lvl), .we_lvl(we_lvl), .addr_s(addr_s),
        .ctr(rfsh_row), .state(kind), .row(row_addr), .col(col_addr),
        .col_load(col_load), .rfsh_done(rfsh_done), .tm(test_mode), .ctr_inc(ctr_inc)
    );

    dram_rfsh_counter #(.W(ADDR_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .count(rfsh_row)
    );

    // Present the cycle kind as its plain encoding.
    always_comb cycle_kind = kind;
endmodule

// File: rtl/dram_rfsh_ctl_chk.sv
// Checker for dram_rfsh_ctl. It relates the registered outputs to one
// another over time and is attached by bind.
module dram_rfsh_ctl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] row_addr,
    input logic              col_load,
    input logic [2:0]        cycle_kind,
    input logic              rfsh_done,
    input logic              test_mode,
    input logic [ADDR_W-1:0] rfsh_row
);
    // R6
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_row != $past(rfsh_row)) |-> (rfsh_row == ADDR_W'($past(rfsh_row) + 1'b1)) && rfsh_done);

    // R7
    tm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> cycle_kind == 3'd4);

    // R4
    tm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cycle_kind == 3'd3) || (cycle_kind == 3'd0 && rfsh_done));

    // R3
    col_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_load |-> (cycle_kind == 3'd2) || (cycle_kind == 3'd5));

    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind != 3'd0 && $past(cycle_kind) != 3'd0) |-> $stable(row_addr));

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_done |-> cycle_kind == 3'd0 && $past(cycle_kind) != 3'd2 && $past(cycle_kind) != 3'd0);
endmodule

bind dram_rfsh_ctl dram_rfsh_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_load(col_load),
    .cycle_kind(cycle_kind), .rfsh_done(rfsh_done), .test_mode(test_mode),
    .rfsh_row(rfsh_row)
);

// File: tb/dram_rfsh_ctl_tb_top.sv
// Bench for dram_rfsh_ctl: directed corner cases plus seeded random cycles,
// checked against a bench reference model.
module dram_rfsh_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] row_addr, col_addr, rfsh_row;
    logic [2:0]    cycle_kind;
    logic          col_load, rfsh_done, test_mode;

    int            n_run = 0, n_fail = 0;
    logic [AW-1:0] m_ctr = '0;
    logic          m_tm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_rfsh_ctl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr_in(addr_in), .row_addr(row_addr), .col_addr(col_addr),
        .col_load(col_load), .cycle_kind(cycle_kind), .rfsh_done(rfsh_done),
        .test_mode(test_mode), .rfsh_row(rfsh_row)
    );

    function automatic logic [AW-1:0] next_ctr(input logic [AW-1:0] c);
        return (c == AW'(1023)) ? '0 : c + 1'b1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Row cycle from pins; ncol column strobes (0 gives a row-only refresh).
    task automatic row_cycle(input logic [AW-1:0] r, input int ncol);
        addr_in = r; ras_n = 1'b0; tick(2);
        chk("R2 kind", cycle_kind, 1); chk("R2 row", row_addr, r);
        for (int i = 0; i < ncol; i++) begin
            logic [AW-1:0] c;
            c = AW'($urandom);
            addr_in = c; cas_n = 1'b0; tick(2);
            chk("R3 kind", cycle_kind, 2); chk("R3 col", col_addr, c); chk("R3 load", col_load, 1);
            cas_n = 1'b1; tick(2);
        end
        ras_n = 1'b1; cas_n = 1'b1; tick(2);
        chk("R9 kind idle", cycle_kind, 0);
        if (ncol == 0) begin
            m_tm = 1'b0;
            chk("R4 done", rfsh_done, 1); chk("R4 tm", test_mode, 0);
        end else begin
            chk("R9 no done", rfsh_done, 0); chk("R9 tm kept", test_mode, m_tm);
        end
        tick(1);
    endtask

    // Counter cycle: CAS before RAS, optional WE low and counter-test columns.
    task automatic cbr_cycle(input logic we, input int ncol, input logic full);
        cas_n = 1'b0; we_n = we; tick(1);
        addr_in = AW'($urandom); ras_n = 1'b0; tick(2);
        m_tm = ~we;
        if (full) begin
            chk(we ? "R5 kind" : "R7 kind", cycle_kind, we ? 3 : 4);
            chk(we ? "R5 row" : "R7 row", row_addr, m_ctr);
            chk(we ? "R5 tm" : "R7 tm", test_mode, m_tm);
        end
        we_n = 1'b1;
        for (int i = 0; i < ncol; i++) begin
            logic [AW-1:0] c;
            c = AW'($urandom);
            cas_n = 1'b1; tick(2);
            addr_in = c; cas_n = 1'b0; tick(2);
            chk("R8 kind", cycle_kind, 5); chk("R8 col", col_addr, c);
            chk("R8 load", col_load, 1); chk("R8 row", row_addr, m_ctr);
        end
        ras_n = 1'b1; cas_n = 1'b1; tick(2);
        m_ctr = next_ctr(m_ctr);
        if (full) begin
            chk("R6 done", rfsh_done, 1); chk("R6 ctr", rfsh_row, m_ctr);
            chk("R9 kind idle", cycle_kind, 0);
        end
        tick(1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        chk("R1 kind", cycle_kind, 0); chk("R1 tm", test_mode, 0);
        chk("R1 ctr", rfsh_row, 0); chk("R1 row", row_addr, 0);
        chk("R1 col", col_addr, 0); chk("R1 load", col_load, 0); chk("R1 done", rfsh_done, 0);
        rst_n = 1'b1; tick(2);
        // Directed: access with page mode, row-only refresh, test entry and exit.
        row_cycle(10'h2A5, 3);
        row_cycle(10'h155, 0);
        cbr_cycle(1'b0, 0, 1'b1);
        row_cycle(10'h0F0, 1);
        row_cycle(10'h001, 0);
        cbr_cycle(1'b0, 2, 1'b1);
        cbr_cycle(1'b1, 1, 1'b1);
        // R6 wrap: many plain refreshes take the counter through 1023 -> 0.
        for (int i = 0; i < 1030; i++) cbr_cycle(1'b1, 0, 1'b0);
        chk("R6 wrap ctr", rfsh_row, m_ctr);
        cbr_cycle(1'b1, 0, 1'b1);
        // Random mix of all cycle kinds.
        for (int i = 0; i < 300; i++) begin
            case ($urandom_range(0, 3))
                0: row_cycle(AW'($urandom), 0);
                1: row_cycle(AW'($urandom), $urandom_range(1, 3));
                2: cbr_cycle(1'b1, $urandom_range(0, 2), 1'b1);
                default: cbr_cycle(1'b0, $urandom_range(0, 2), 1'b1);
            endcase
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule